// File: doc/BRIEF.md
# Abstract Register Command Instruction Generator

This block sits in a debug memory window. A debugger asks it to move a value between the data0 exchange word and one integer register of a halted hart. The block does not touch the register file. It writes two instruction words into a fixed pair of slots, and a hart parked in debug memory then runs them. The first slot holds the transfer: a load into the register, a store out of it, or a no-op when no transfer is wanted. The second slot either falls through into the program buffer that follows it, or stops with a breakpoint so that the hart returns to its park loop.

The region is contiguous. The two generated slots come first, then `PB_WORDS` program buffer words, and then data0 at byte address `DATA0_ADDR`. Because data0 lies inside the signed 12-bit immediate range, every transfer can address it relative to x0. A command is taken on a one-cycle `start` strobe. One cycle later, the block reports on exactly one of two outputs whether it accepted or refused the command.

Top module: `abscmd_gen`

## Requirements
- R1: After reset, slot 0 holds 0x00000013 (no-op), slot 1 holds 0x00100073 (breakpoint), and `done_ok` and `done_err` are low.
- R2: Slot 0 sits at byte address `DATA0_ADDR - 4*PB_WORDS - 8` and slot 1 at `DATA0_ADDR - 4*PB_WORDS - 4`. For every other address, `rd_hit` is low and `rd_data` is zero.
- R3: With `transfer` and `write` both set, slot 0 becomes a load. Its fields are imm[11:0]=`DATA0_ADDR` in bits 31:20, rs1=x0 in bits 19:15, funct3 in bits 14:12, rd=`regno[4:0]` in bits 11:7, and the opcode in bits 6:0.
- R4: With `transfer` set and `write` clear, slot 0 becomes a store. Its fields are imm[11:5] in bits 31:25, rs2=`regno[4:0]` in bits 24:20, rs1=x0 in bits 19:15, funct3 in bits 14:12, imm[4:0] in bits 11:7, and opcode 0100011 in bits 6:0.
- R5: The value of `size` selects the transfer form:
  - `size`=2 (32-bit): load funct3 010 with opcode 0000011, store funct3 010.
  - `size`=3 (64-bit): load funct3 011 with opcode 0000011, store funct3 011.
  - `size`=4 (128-bit): load funct3 010 with opcode 0001111, store funct3 100.
- R6: With `transfer` clear, slot 0 becomes the no-op 0x00000013 and the command is accepted, whatever the values of `regno`, `size` and `write`.
- R7: Slot 1 becomes 0x00000013 when `postexec` is set and 0x00100073 when it is clear.
- R8: The cycle after `start`, exactly one of `done_ok` and `done_err` is high for one cycle. Neither rises without a preceding `start`.
- R9: With `transfer` set, a `regno` outside 0x1000..0x101F or a `size` outside 2..`MAX_SIZE` raises `done_err` and leaves both slots unchanged.
- R10: The read port is combinational on the stored slots. A read in the same cycle as `start` returns the old word, and the new word appears after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command strobe |
| regno | input | 16 | Register number of the command |
| size | input | 3 | Transfer size code (2, 3 or 4) |
| transfer | input | 1 | Perform the register transfer |
| write | input | 1 | 1: data0 to register, 0: register to data0 |
| postexec | input | 1 | Continue into the program buffer afterwards |
| rd_addr | input | 12 | Byte address of the read port |
| rd_data | output | 32 | Instruction word at `rd_addr` |
| rd_hit | output | 1 | `rd_addr` selects a generated slot |
| done_ok | output | 1 | Command accepted, slots rewritten |
| done_err | output | 1 | Command refused as not supported |

## Verification
A hart fetching from the slots and a new command rewriting them can fall in the same cycle. The bench provokes this by holding `rd_addr` on slot 0 while it raises `start` with a command that changes that word. Within that cycle it expects the previous instruction on `rd_data`. After the edge it expects the new encoding, as computed by the bench's own arithmetic encoder. The same approach checks that a refused command leaves the words the hart would fetch untouched.

// File: rtl/abscmd_pkg.sv
package abscmd_pkg;

  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;

  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] OPC_MISCMEM = 7'b0001111;
  localparam logic [6:0] OPC_STORE   = 7'b0100011;

  localparam logic [15:0] GPR_FIRST = 16'h1000;
  localparam logic [15:0] GPR_LAST  = 16'h101F;

  typedef struct packed {
    logic [2:0] funct3;
    logic [6:0] opcode;
  } mem_op_t;

  function automatic logic [31:0] enc_itype(input logic [11:0] imm,
                                            input logic [4:0]  rs1,
                                            input mem_op_t     op,
                                            input logic [4:0]  rd);
    return {imm, rs1, op.funct3, rd, op.opcode};
  endfunction

  function automatic logic [31:0] enc_stype(input logic [11:0] imm,
                                            input logic [4:0]  rs2,
                                            input logic [4:0]  rs1,
                                            input mem_op_t     op);
    return {imm[11:5], rs2, rs1, op.funct3, imm[4:0], op.opcode};
  endfunction

  function automatic mem_op_t load_form(input logic [2:0] sz);
    mem_op_t r;
    case (sz)
      3'd3:    r = '{funct3: 3'b011, opcode: OPC_LOAD};
      3'd4:    r = '{funct3: 3'b010, opcode: OPC_MISCMEM};
      default: r = '{funct3: 3'b010, opcode: OPC_LOAD};
    endcase
    return r;
  endfunction

  function automatic mem_op_t store_form(input logic [2:0] sz);
    mem_op_t r;
    case (sz)
      3'd3:    r = '{funct3: 3'b011, opcode: OPC_STORE};
      3'd4:    r = '{funct3: 3'b100, opcode: OPC_STORE};
      default: r = '{funct3: 3'b010, opcode: OPC_STORE};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/abscmd_decode.sv
module abscmd_decode
  import abscmd_pkg::*;
#(
  parameter int MAX_SIZE = 4
) (
  input  logic [15:0] regno,
  input  logic [2:0]  size,
  input  logic        transfer,
  output logic        accept,
  output logic [4:0]  gpr
);
  logic regno_in_range;
  logic size_ok;

  assign regno_in_range = (regno >= GPR_FIRST) && (regno <= GPR_LAST);
  assign size_ok        = (size >= 3'd2) && (32'(size) <= MAX_SIZE);
  assign accept         = !transfer || (regno_in_range && size_ok);
  assign gpr            = regno[4:0];
endmodule

// File: rtl/abscmd_encode.sv
module abscmd_encode
  import abscmd_pkg::*;
#(
  parameter logic [11:0] DATA0_ADDR = 12'h400
) (
  input  logic [4:0]  gpr,
  input  logic [2:0]  size,
  input  logic        transfer,
  input  logic        write,
  input  logic        postexec,
  output logic [31:0] word0,
  output logic [31:0] word1
);
  logic [31:0] ld_word;
  logic [31:0] st_word;

  assign ld_word = enc_itype(DATA0_ADDR, 5'd0, load_form(size), gpr);
  assign st_word = enc_stype(DATA0_ADDR, gpr, 5'd0, store_form(size));

  always_comb begin
    if (!transfer)  word0 = INSN_NOP;
    else if (write) word0 = ld_word;
    else            word0 = st_word;
    word1 = postexec ? INSN_NOP : INSN_EBREAK;
  end
endmodule

// File: rtl/abscmd_slots.sv
module abscmd_slots
  import abscmd_pkg::*;
#(
  parameter logic [11:0] DATA0_ADDR = 12'h400,
  parameter int          PB_WORDS   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_en,
  input  logic [31:0] new0,
  input  logic [31:0] new1,
  input  logic [11:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_hit,
  output logic [31:0] slot0,
  output logic [31:0] slot1
);
  localparam int NSLOT   = 2;
  localparam int PB_BASE = int'(DATA0_ADDR) - 4 * PB_WORDS;
  localparam int SLOT_BASE = PB_BASE - 4 * NSLOT;

  logic [31:0] words [NSLOT];
  logic [31:0] nxt   [NSLOT];
  logic [NSLOT-1:0] sel;

  assign nxt[0] = new0;
  assign nxt[1] = new1;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [31:0] RST_VAL = (i == NSLOT - 1) ? INSN_EBREAK : INSN_NOP;
    always_ff @(posedge clk) begin
      if (!rst_n)       words[i] <= RST_VAL;
      else if (load_en) words[i] <= nxt[i];
    end
    assign sel[i] = (rd_addr == 12'(SLOT_BASE + 4 * i));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NSLOT; i++)
      if (sel[i]) rd_data = words[i];
  end

  assign rd_hit = |sel;
  assign slot0  = words[0];
  assign slot1  = words[NSLOT-1];

  assert_slot1_form_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (slot1 == INSN_NOP) || (slot1 == INSN_EBREAK));

  assert_one_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_data == 32'd0));
endmodule

// File: rtl/abscmd_gen.sv
module abscmd_gen
  import abscmd_pkg::*;
#(
  parameter logic [11:0] DATA0_ADDR = 12'h400,
  parameter int          PB_WORDS   = 8,
  parameter int          MAX_SIZE   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] regno,
  input  logic [2:0]  size,
  input  logic        transfer,
  input  logic        write,
  input  logic        postexec,
  input  logic [11:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_hit,
  output logic        done_ok,
  output logic        done_err
);
  logic        cmd_accept;
  logic [4:0]  cmd_gpr;
  logic [31:0] gen_w0, gen_w1;
  logic [31:0] slot0, slot1;
  logic        load_en;

  abscmd_decode #(.MAX_SIZE(MAX_SIZE)) u_decode (
    .regno(regno), .size(size), .transfer(transfer),
    .accept(cmd_accept), .gpr(cmd_gpr)
  );

  abscmd_encode #(.DATA0_ADDR(DATA0_ADDR)) u_encode (
    .gpr(cmd_gpr), .size(size), .transfer(transfer), .write(write),
    .postexec(postexec), .word0(gen_w0), .word1(gen_w1)
  );

  assign load_en = start && cmd_accept;

  abscmd_slots #(.DATA0_ADDR(DATA0_ADDR), .PB_WORDS(PB_WORDS)) u_slots (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .new0(gen_w0), .new1(gen_w1),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .slot0(slot0), .slot1(slot1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_ok  <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done_ok  <= start && cmd_accept;
      done_err <= start && !cmd_accept;
    end
  end

  assert_answer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (done_ok ^ done_err));

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ok || done_err) |-> $past(start));

  assert_err_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> ($stable(slot0) && $stable(slot1)));

  assert_slot0_opcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot0 == INSN_NOP) || (slot0[6:0] == OPC_LOAD) ||
    (slot0[6:0] == OPC_MISCMEM) || (slot0[6:0] == OPC_STORE));
endmodule

// File: tb/abscmd_gen_tb.sv
module abscmd_gen_tb;
  localparam logic [11:0] D0  = 12'h414;
  localparam int          PBW = 8;
  localparam logic [11:0] S0  = D0 - 12'(4 * PBW) - 12'd8;
  localparam logic [11:0] S1  = S0 + 12'd4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regno = '0;
  logic [2:0]  size = '0;
  logic        transfer = 1'b0, write = 1'b0, postexec = 1'b0;
  logic [11:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_hit, done_ok, done_err;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  abscmd_gen #(.DATA0_ADDR(D0), .PB_WORDS(PBW), .MAX_SIZE(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .regno(regno), .size(size),
    .transfer(transfer), .write(write), .postexec(postexec),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_hit(rd_hit),
    .done_ok(done_ok), .done_err(done_err)
  );

  // fields: regno[22:7] size[6:4] transfer[3] write[2] postexec[1] accepted[0]
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {16'h1005, 3'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h1005, 3'd2, 1'b1, 1'b0, 1'b1, 1'b1},
    {16'h101F, 3'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    {16'h1000, 3'd3, 1'b1, 1'b0, 1'b0, 1'b1},
    {16'h1011, 3'd4, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h100A, 3'd4, 1'b1, 1'b0, 1'b1, 1'b1},
    {16'h1020, 3'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h0FFF, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h1003, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h1003, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0},
    {16'h0300, 3'd7, 1'b0, 1'b1, 1'b1, 1'b1},
    {16'h1002, 3'd2, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'h0005, 3'd2, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  function automatic logic [31:0] ref_w0(input logic tr, input logic wr,
                                         input logic [2:0] sz, input int r);
    int unsigned f3, op, imm;
    if (!tr) return 32'h13;
    imm = int'(D0);
    if (wr) begin
      f3 = (sz == 3) ? 3 : 2;
      op = (sz == 4) ? 15 : 3;
      return 32'(imm * 1048576 + f3 * 4096 + r * 128 + op);
    end
    f3 = (sz == 3) ? 3 : (sz == 4) ? 4 : 2;
    op = 35;
    return 32'((imm / 32) * 33554432 + r * 1048576 + f3 * 4096 +
               (imm % 32) * 128 + op);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_at(input logic [11:0] a, output logic [31:0] d, output logic h);
    rd_addr = a;
    #1;
    d = rd_data;
    h = rd_hit;
  endtask

  logic [31:0] exp0 = 32'h13, exp1 = 32'h0010_0073;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic h;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    read_at(S0, d, h); check("R1 slot0", d, 32'h13);
    read_at(S1, d, h); check("R1 slot1", d, 32'h0010_0073);
    check("R1 done_ok", {31'd0, done_ok}, 0);
    check("R1 done_err", {31'd0, done_err}, 0);
    // R2 layout
    read_at(S0, d, h); check("R2 hit slot0", {31'd0, h}, 1);
    read_at(S1, d, h); check("R2 hit slot1", {31'd0, h}, 1);
    read_at(S0 - 12'd4, d, h); check("R2 miss below", {31'd0, h}, 0);
    check("R2 miss data", d, 0);
    read_at(S1 + 12'd4, d, h); check("R2 miss progbuf", {31'd0, h}, 0);
    read_at(D0, d, h); check("R2 miss data0", {31'd0, h}, 0);
    check("R2 miss data0 word", d, 0);

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      v = VEC[i];
      @(negedge clk);
      regno = v[22:7]; size = v[6:4]; transfer = v[3];
      write = v[2]; postexec = v[1]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R8 done_ok", {31'd0, done_ok}, {31'd0, v[0]});
      check(v[0] ? "R8 done_err" : "R9 done_err", {31'd0, done_err}, {31'd0, !v[0]});
      if (v[0]) begin
        exp0 = ref_w0(v[3], v[2], v[6:4], int'(v[11:7]));
        exp1 = v[1] ? 32'h13 : 32'h0010_0073;
      end
      read_at(S0, d, h);
      check(!v[0] ? "R9 slot0 kept" : !v[3] ? "R6 slot0 nop" :
            v[2] ? "R3 R5 load" : "R4 R5 store", d, exp0);
      read_at(S1, d, h);
      check(v[0] ? "R7 slot1" : "R9 slot1 kept", d, exp1);
      @(negedge clk);
      check("R8 pulse ends", {30'd0, done_ok, done_err}, 0);
    end

    // R10 same-cycle read and rewrite
    @(negedge clk);
    regno = 16'h1007; size = 3'd2; transfer = 1'b1; write = 1'b0;
    postexec = 1'b0; start = 1'b1;
    read_at(S0, d, h);
    check("R10 old word", d, exp0);
    @(negedge clk);
    start = 1'b0;
    read_at(S0, d, h);
    exp0 = ref_w0(1'b1, 1'b0, 3'd2, 7);
    check("R10 new word", d, exp0);

    // R8 no start, no answer
    repeat (2) @(negedge clk);
    check("R8 idle", {30'd0, done_ok, done_err}, 0);

    // R1 reset again restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    read_at(S0, d, h); check("R1 slot0 after reset", d, 32'h13);
    read_at(S1, d, h); check("R1 slot1 after reset", d, 32'h0010_0073);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule